// File: doc/BRIEF.md
# Framebuffer Geometry Latch

This block sits between the display register bank and the scan-out path. It reads the framebuffer base address, the size word, the colour mode, the sync configuration, a second display configuration word and a border colour. From these it derives everything the pixel fetch engine needs for one frame: the base address, the row pitch in bytes, the visible width in pixels, the visible height in lines, a colour format code, an output enable, and a forced-blank select with its fill colour.

The decoded set changes only on a frame boundary. The boundary is the cycle in which the line position from the raster block moves onto or past the end of vertical retrace. This keeps the scan-out stable in mid-frame while software rewrites the registers. There is one exception. A base-address write that lands while the raster is in vertical retrace applies the whole decoded set at once, so a page flip done during blanking is shown on the next frame. A one-cycle strobe tells the display side when the latched width, height or format differs from the set it replaces.

Top module: `fb_geom_latch`

## Requirements
- R1: The size word splits into three FIELD_W-bit fields: words-per-line minus one at bit 0, lines-per-field minus one at bit FIELD_W, and the modulo at bit 2*FIELD_W. The latched row pitch is `stride_o` = 4 × (words field + modulo field).
- R2: Mode bits 3:2 give the format code on `fmt_o`. Codes 0 and 1 (16-bit pixels) give a width of 2 × (words field + 1). Code 2 (24-bit packed) gives a width of floor(4 × (words field + 1) / 3). Code 3 (32-bit) gives a width of words field + 1.
- R3: The height is the lines field + 1. It is doubled when interlace (sync configuration bit 4) is set.
- R4: A decoded width of SMALL_LIM (8) or less is replaced by DEF_H (640). A decoded height of 8 or less, taken after any doubling, is replaced by DEF_V (480).
- R5: `enable_o` is mode bit 0 AND sync configuration bit 3. `blank_o` is bit 3 of the second configuration word. `border_o` is the low 25 bits of the border colour.
- R6: A base-address write keeps only bits ADDR_W-1:2 of the written data. The other bits read as zero on `base_o`.
- R7: A base-address write while `in_retrace_i` is high updates every output with the new base and the current configuration on the clock edge that samples the write.
- R8: A base-address write while `in_retrace_i` is low leaves `base_o` unchanged until the next frame latch, which then applies it.
- R9: The frame latch fires on an edge where `line_i` ≥ RETRACE_END and the previous line was below RETRACE_END or above the current line (wrap). Configuration changes at any other time do not reach the outputs.
- R10: `fmt_change_o` is high for one cycle after a latch whose width, height or format differs from the previously latched values. It stays low after a latch that changes none of them.
- R11: After reset: base 0, pitch 0, width 640, height 480, format 0, enable 0, blank 0, border 0, strobe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_wr_i | input | 1 | Base-address register write strobe |
| base_wdata_i | input | 32 | Base-address write data |
| disp_size_i | input | 32 | Size word (modulo, lines, words) |
| disp_mode_i | input | 32 | Mode word (bit 0 enable, bits 3:2 format) |
| sync_cfg_i | input | 32 | Sync configuration (bit 3 video out, bit 4 interlace) |
| disp_cfg2_i | input | 32 | Second configuration word (bit 3 forced blank) |
| border_i | input | 32 | Border colour |
| in_retrace_i | input | 1 | Raster is inside vertical retrace |
| line_i | input | LINE_W | Current raster line |
| base_o | output | ADDR_W | Latched frame base address |
| stride_o | output | FIELD_W+3 | Row pitch in bytes |
| hres_o | output | FIELD_W+2 | Width in pixels |
| vres_o | output | FIELD_W+2 | Height in lines |
| fmt_o | output | 2 | Colour format code |
| enable_o | output | 1 | Display output enabled |
| blank_o | output | 1 | Show a blank frame in the border colour |
| border_o | output | BORDER_W | Border colour |
| fmt_change_o | output | 1 | Width, height or format changed at the last latch |

## Verification
The bench keeps FIELD_W at 10, LINE_W at 10 and ADDR_W at 24, so the size fields line up with the real 10-bit register layout. It lowers RETRACE_END to 4, so a frame boundary can be produced with two line values instead of a full field. It can also jump the line to 100 and back to 50 to cause a wrap crossing. With these values every colour mode can be driven on both sides of the 8-pixel fallback threshold, including the 24-bit case where the division rounds down onto the threshold. It also reaches interlace doubling that lifts a height just over the threshold, or leaves it at exactly 8.

// File: rtl/fb_geom_pkg.sv
package fb_geom_pkg;
  typedef enum logic [1:0] {
    FMT_ARGB1555 = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_RGB888   = 2'd2,
    FMT_ARGB8888 = 2'd3
  } fb_fmt_e;

  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_FMT_LSB  = 2;
  localparam int SYNC_VOUT_BIT = 3;
  localparam int SYNC_ILACE_BIT = 4;
  localparam int CFG2_BLANK_BIT = 3;
endpackage

// File: rtl/fb_geom_decode.sv
module fb_geom_decode
  import fb_geom_pkg::*;
#(
  parameter int FIELD_W   = 10,
  parameter int SMALL_LIM = 8,
  parameter int DEF_H     = 640,
  parameter int DEF_V     = 480,
  localparam int STRIDE_W = FIELD_W + 3,
  localparam int RES_W    = FIELD_W + 2
) (
  input  logic [3*FIELD_W-1:0] size_i,
  input  logic [1:0]           fmt_i,
  input  logic                 ilace_i,
  output logic [STRIDE_W-1:0]  stride_o,
  output logic [RES_W-1:0]     hres_o,
  output logic [RES_W-1:0]     vres_o
);
  logic [FIELD_W-1:0]  words, lines_m1, modulo;
  logic [FIELD_W:0]    ppl, lpf;
  logic [FIELD_W+2:0]  quad;
  logic [RES_W-1:0]    h_raw, v_raw;

  assign words    = size_i[FIELD_W-1:0];
  assign lines_m1 = size_i[2*FIELD_W-1:FIELD_W];
  assign modulo   = size_i[3*FIELD_W-1:2*FIELD_W];
  assign ppl      = {1'b0, words} + 1'b1;
  assign lpf      = {1'b0, lines_m1} + 1'b1;
  assign quad     = {ppl, 2'b00};

  // (words + 1) + (modulo - 1), in 32-bit units, times four
  assign stride_o = {({1'b0, words} + {1'b0, modulo}), 2'b00};

  always_comb begin
    unique case (fb_fmt_e'(fmt_i))
      FMT_ARGB1555, FMT_RGB565: h_raw = {ppl, 1'b0};
      FMT_RGB888:               h_raw = RES_W'(quad / 3);
      default:                  h_raw = RES_W'(ppl);
    endcase
  end

  assign v_raw  = ilace_i ? {lpf, 1'b0} : RES_W'(lpf);
  assign hres_o = (h_raw <= RES_W'(SMALL_LIM)) ? RES_W'(DEF_H) : h_raw;
  assign vres_o = (v_raw <= RES_W'(SMALL_LIM)) ? RES_W'(DEF_V) : v_raw;

  always_comb begin
    a_hres_floor_r4: assert (hres_o > RES_W'(SMALL_LIM));
    a_vres_floor_r4: assert (vres_o > RES_W'(SMALL_LIM));
  end
endmodule

// File: rtl/fb_frame_tick.sv
module fb_frame_tick #(
  parameter int LINE_W      = 10,
  parameter int RETRACE_END = 42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  output logic              tick_o
);
  logic [LINE_W-1:0] prev_line;
  localparam logic [LINE_W-1:0] END_L = LINE_W'(RETRACE_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_line <= '0;
    else         prev_line <= line_i;
  end

  // crossing the retrace end, either directly or through a field wrap
  assign tick_o = (line_i >= END_L) && ((prev_line < END_L) || (prev_line > line_i));

  p_tick_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (line_i >= END_L));
  p_no_retick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || (line_i != $past(line_i))));
endmodule

// File: rtl/fb_base_reg.sv
module fb_base_reg #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-3:0] held;
  logic [ADDR_W-3:0] wval;
  logic              unused_wbits;

  assign wval = wdata_i[ADDR_W-1:2];
  assign unused_wbits = ^{wdata_i[31:ADDR_W], wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held <= '0;
    else if (wr_i) held <= wval;
  end

  // a write is visible to the latch in the same cycle
  assign next_o = {(wr_i ? wval : held), 2'b00};

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(held));
endmodule

// File: rtl/fb_geom_latch.sv
module fb_geom_latch
  import fb_geom_pkg::*;
#(
  parameter int FIELD_W     = 10,
  parameter int LINE_W      = 10,
  parameter int ADDR_W      = 24,
  parameter int BORDER_W    = 25,
  parameter int RETRACE_END = 42,
  parameter int SMALL_LIM   = 8,
  parameter int DEF_H       = 640,
  parameter int DEF_V       = 480,
  localparam int STRIDE_W   = FIELD_W + 3,
  localparam int RES_W      = FIELD_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                base_wr_i,
  input  logic [31:0]         base_wdata_i,
  input  logic [31:0]         disp_size_i,
  input  logic [31:0]         disp_mode_i,
  input  logic [31:0]         sync_cfg_i,
  input  logic [31:0]         disp_cfg2_i,
  input  logic [31:0]         border_i,
  input  logic                in_retrace_i,
  input  logic [LINE_W-1:0]   line_i,
  output logic [ADDR_W-1:0]   base_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [RES_W-1:0]    hres_o,
  output logic [RES_W-1:0]    vres_o,
  output logic [1:0]          fmt_o,
  output logic                enable_o,
  output logic                blank_o,
  output logic [BORDER_W-1:0] border_o,
  output logic                fmt_change_o
);
  logic                tick, apply, differs;
  logic [ADDR_W-1:0]   base_nx;
  logic [STRIDE_W-1:0] stride_nx;
  logic [RES_W-1:0]    hres_nx, vres_nx;
  logic [1:0]          fmt_nx;
  logic                unused_bits;

  assign unused_bits = ^{disp_size_i[31:3*FIELD_W], disp_mode_i[31:4], disp_mode_i[1],
                         sync_cfg_i[31:5], sync_cfg_i[2:0], disp_cfg2_i[31:4],
                         disp_cfg2_i[2:0], border_i[31:BORDER_W]};

  fb_frame_tick #(.LINE_W(LINE_W), .RETRACE_END(RETRACE_END)) u_tick (
    .clk_i, .rst_ni, .line_i, .tick_o(tick)
  );

  fb_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i, .rst_ni, .wr_i(base_wr_i), .wdata_i(base_wdata_i), .next_o(base_nx)
  );

  assign fmt_nx = disp_mode_i[MODE_FMT_LSB+1:MODE_FMT_LSB];

  fb_geom_decode #(
    .FIELD_W(FIELD_W), .SMALL_LIM(SMALL_LIM), .DEF_H(DEF_H), .DEF_V(DEF_V)
  ) u_dec (
    .size_i  (disp_size_i[3*FIELD_W-1:0]),
    .fmt_i   (fmt_nx),
    .ilace_i (sync_cfg_i[SYNC_ILACE_BIT]),
    .stride_o(stride_nx),
    .hres_o  (hres_nx),
    .vres_o  (vres_nx)
  );

  assign apply   = tick || (base_wr_i && in_retrace_i);
  assign differs = (hres_nx != hres_o) || (vres_nx != vres_o) || (fmt_nx != fmt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o       <= '0;
      stride_o     <= '0;
      hres_o       <= RES_W'(DEF_H);
      vres_o       <= RES_W'(DEF_V);
      fmt_o        <= '0;
      enable_o     <= 1'b0;
      blank_o      <= 1'b0;
      border_o     <= '0;
      fmt_change_o <= 1'b0;
    end else begin
      fmt_change_o <= apply && differs;
      if (apply) begin
        base_o   <= base_nx;
        stride_o <= stride_nx;
        hres_o   <= hres_nx;
        vres_o   <= vres_nx;
        fmt_o    <= fmt_nx;
        enable_o <= disp_mode_i[MODE_EN_BIT] && sync_cfg_i[SYNC_VOUT_BIT];
        blank_o  <= disp_cfg2_i[CFG2_BLANK_BIT];
        border_o <= border_i[BORDER_W-1:0];
      end
    end
  end

  p_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> ($stable(base_o) && $stable(stride_o) && $stable(hres_o) && $stable(vres_o)));
  p_pulse_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fmt_change_o) |-> $past(apply));
  p_no_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && !differs) |=> !fmt_change_o);
  p_base_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[1:0] == 2'b00);
endmodule

// File: tb/fb_geom_latch_test.sv
`timescale 1ns/1ps
module fb_geom_latch_test;
  localparam int END_L = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0, size = '0, mode = '0, sync = '0, cfg2 = '0, border = '0;
  logic        in_retrace = 1'b0;
  logic [9:0]  line = '0;
  logic [23:0] base_o;
  logic [12:0] stride_o;
  logic [11:0] hres_o, vres_o;
  logic [1:0]  fmt_o;
  logic        enable_o, blank_o, fmt_change_o;
  logic [24:0] border_o;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  fb_geom_latch #(.RETRACE_END(END_L)) uut (
    .clk_i(clk), .rst_ni, .base_wr_i(base_wr), .base_wdata_i(base_wdata),
    .disp_size_i(size), .disp_mode_i(mode), .sync_cfg_i(sync), .disp_cfg2_i(cfg2),
    .border_i(border), .in_retrace_i(in_retrace), .line_i(line),
    .base_o, .stride_o, .hres_o, .vres_o, .fmt_o, .enable_o, .blank_o, .border_o,
    .fmt_change_o
  );

  typedef struct packed {
    logic [31:0] size;
    logic [3:0]  mode;
    logic [4:0]  sync;
    logic [12:0] stride;
    logic [11:0] hres;
    logic [11:0] vres;
  } vec_t;

  // R1 R2 R3 R4 vectors: size, mode, sync, pitch, width, height
  localparam vec_t VEC [10] = '{
    '{32'h0013BD3F, 4'b0001, 5'h18, 13'd1280, 12'd640, 12'd480},
    '{32'h0013BD3F, 4'b0101, 5'h08, 13'd1280, 12'd640, 12'd240},
    '{32'h00077DDF, 4'b1001, 5'h08, 13'd1916, 12'd640, 12'd480},
    '{32'h00177E7F, 4'b1101, 5'h18, 13'd2560, 12'd640, 12'd960},
    '{32'h00000C03, 4'b0001, 5'h08, 13'd12,   12'd640, 12'd480},
    '{32'h00001004, 4'b0001, 5'h18, 13'd16,   12'd10,  12'd10},
    '{32'h00002006, 4'b1001, 5'h08, 13'd24,   12'd9,   12'd9},
    '{32'h00201C07, 4'b1101, 5'h08, 13'd36,   12'd640, 12'd480},
    '{32'h00000C03, 4'b0101, 5'h18, 13'd12,   12'd640, 12'd480},
    '{32'h00000005, 4'b1001, 5'h18, 13'd20,   12'd640, 12'd480}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic frame();
    @(negedge clk) line = '0;
    @(negedge clk) line = 10'(END_L);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] ph, pv;
    logic [1:0]  pf;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 base", 32'(base_o), 0);
    chk("R11 stride", 32'(stride_o), 0);
    chk("R11 hres", 32'(hres_o), 640);
    chk("R11 vres", 32'(vres_o), 480);
    chk("R11 fmt/en/blank/chg", {28'h0, fmt_o, enable_o, blank_o | fmt_change_o}, 0);
    rst_ni = 1'b1;

    ph = 12'd640; pv = 12'd480; pf = 2'd0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      size = VEC[i].size; mode = {28'h0, VEC[i].mode}; sync = {27'h0, VEC[i].sync};
      frame();
      chk($sformatf("R1 stride v%0d", i), 32'(stride_o), 32'(VEC[i].stride));
      chk($sformatf("R2 R4 hres v%0d", i), 32'(hres_o), 32'(VEC[i].hres));
      chk($sformatf("R3 R4 vres v%0d", i), 32'(vres_o), 32'(VEC[i].vres));
      chk($sformatf("R2 fmt v%0d", i), 32'(fmt_o), 32'(VEC[i].mode[3:2]));
      chk($sformatf("R10 strobe v%0d", i), 32'(fmt_change_o),
          32'((VEC[i].hres != ph) || (VEC[i].vres != pv) || (VEC[i].mode[3:2] != pf)));
      ph = VEC[i].hres; pv = VEC[i].vres; pf = VEC[i].mode[3:2];
    end
    @(negedge clk);
    chk("R10 strobe one cycle", 32'(fmt_change_o), 0);

    // R5 enable, blank, border
    mode = 32'h0000_0004; sync = 32'h8; frame();
    chk("R5 enable off by mode", 32'(enable_o), 0);
    mode = 32'h5; sync = 32'h10; frame();
    chk("R5 enable off by sync", 32'(enable_o), 0);
    sync = 32'h18; cfg2 = 32'h8; border = 32'hFFFF_FFFF; frame();
    chk("R5 enable on", 32'(enable_o), 1);
    chk("R5 blank", 32'(blank_o), 1);
    chk("R5 border", 32'(border_o), 32'h01FF_FFFF);

    // R9 no latch without crossing; then wrap crossing
    @(negedge clk) line = 10'd100;
    @(negedge clk) size = 32'h0000_1004;
    repeat (3) @(negedge clk);
    chk("R9 hold without crossing", 32'(stride_o), 32'd20);
    line = 10'd50;
    @(negedge clk);
    chk("R9 wrap crossing", 32'(stride_o), 32'd16);
    @(negedge clk);

    // R6 R7 immediate apply in retrace
    size = 32'h0000_0C03;
    in_retrace = 1'b1; base_wr = 1'b1; base_wdata = 32'hFFFF_FFFF;
    @(negedge clk) base_wr = 1'b0; in_retrace = 1'b0;
    chk("R6 base mask", 32'(base_o), 32'h00FF_FFFC);
    chk("R7 config applied", 32'(stride_o), 32'd12);

    // R8 deferred apply
    base_wr = 1'b1; base_wdata = 32'h0012_3457;
    @(negedge clk) base_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 base deferred", 32'(base_o), 32'h00FF_FFFC);
    frame();
    chk("R8 base at frame", 32'(base_o), 32'h0012_3454);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule